// File: doc/BRIEF.md
# Direct-Mapped Fetch Miss Classifier

This block is the tag side of a small direct-mapped instruction cache that sits behind a 16-bit program counter. Each fetch request carries a byte address. One clock later the block returns a code that sorts the fetch into one of three classes:

- a hit;
- a first-touch (compulsory) miss;
- a repeat (non-compulsory) miss, where the block was fetched before but has since been pushed out by another block that shares its line.

On any miss the indexed line takes the new tag and becomes valid. Instruction bytes, the refill path and memory latency are not modelled. Only valid bits, tags and a one-bit-per-block reference history are kept.

The history holds one bit for every 16-byte block of the 64 KB space. It is the only record of whether a block has ever been referenced. Because of it, a miss can be split into the two miss classes in the same cycle as the tag compare.

Top module: `icls_classifier`

## Requirements
- R1: A fetch address splits into a byte offset in bits 3:0, a line index in bits 7:4 (16 lines) and a tag in bits 15:8. Bits 15:4 identify the memory block.
- R2: After reset all lines are invalid, so the first fetch to any block reports a compulsory miss. `resValid` is low while reset is held.
- R3: A fetch whose indexed line is valid with an equal tag reports a hit, with `resCode` = 2'b01.
- R4: A miss on a block that has never been referenced since reset reports a compulsory miss, with `resCode` = 2'b10.
- R5: A miss on a block that was referenced earlier but has since been displaced reports a non-compulsory miss, with `resCode` = 2'b11.
- R6: Every miss loads the new tag into the indexed line and marks it valid, so the next fetch to that block hits.
- R7: `resValid` is high for exactly the cycle after each cycle in which `fetchReq` is high. `resCode` is 2'b00 whenever `resValid` is low.
- R8: Fetches on consecutive cycles are accepted, and each fetch sees the line state left by the one before it.
- R9: Reset also clears the reference history, so a block referenced before reset reports a compulsory miss again on its first miss after reset.
- R10: The byte offset has no effect on the outcome: any byte of a resident block hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| fetchReq | input | 1 | Fetch strobe, one fetch per high cycle |
| fetchAddr | input | 16 | Byte address of the fetch |
| resValid | output | 1 | Result valid, one cycle after the strobe |
| resCode | output | 2 | 01 hit, 10 compulsory miss, 11 non-compulsory miss, 00 idle |

## Verification
The assertions check the following properties on every cycle:
- the one-cycle timing of `resValid` against `fetchReq`;
- the idle code when no result is valid;
- a legal class whenever a result is valid;
- a hit on any immediate repeat of the same block, whatever the offset.

Only the directed scenarios can show that each miss is sorted into the right class. That sorting depends on long histories: a block displaced and then returning, a ping-pong between two blocks on one line, and history wiped by reset. The scenarios compare against expected codes worked out by hand from the address split.

// File: rtl/icls_pkg.sv
package icls_pkg;
  typedef enum logic [1:0] {
    RES_IDLE     = 2'b00,
    RES_HIT      = 2'b01,
    RES_COLD     = 2'b10,
    RES_CONFLICT = 2'b11
  } res_code_e;

  typedef struct packed {
    logic install;   // load tag and set valid for the indexed line
    logic markSeen;  // set history bit for the referenced block
  } strobe_t;
endpackage

// File: rtl/icls_datapath.sv
module icls_datapath #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  icls_pkg::strobe_t       strobes,
  input  logic [ADDR_W-OFF_W-1:0] blockAddr,
  output logic                    lineHit,
  output logic                    blockSeen
);
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int TAG_W  = BLK_W - IDX_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int BLOCKS = 1 << BLK_W;

  logic [IDX_W-1:0] lineIdx;
  logic [TAG_W-1:0] lineTag;
  logic [LINES-1:0] validBits;
  logic [TAG_W-1:0] tagStore [LINES];
  logic [BLOCKS-1:0] seenBits;

  assign lineIdx = blockAddr[IDX_W-1:0];
  assign lineTag = blockAddr[BLK_W-1:IDX_W];

  assign lineHit   = validBits[lineIdx] && (tagStore[lineIdx] == lineTag);
  assign blockSeen = seenBits[blockAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      seenBits  <= '0;
    end else begin
      if (strobes.install)  validBits[lineIdx] <= 1'b1;
      if (strobes.markSeen) seenBits[blockAddr] <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rstN) tagStore[g] <= '0;
        else if (strobes.install && lineIdx == IDX_W'(g)) tagStore[g] <= lineTag;
      end
    end
  endgenerate
endmodule

// File: rtl/icls_control.sv
module icls_control (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fetchReq,
  input  logic                lineHit,
  input  logic                blockSeen,
  output icls_pkg::strobe_t   strobes,
  output logic                resValid,
  output logic [1:0]          resCode
);
  import icls_pkg::*;

  res_code_e nextCode;

  always_comb begin
    strobes.install  = fetchReq && !lineHit;
    strobes.markSeen = fetchReq;
    if (!fetchReq)      nextCode = RES_IDLE;
    else if (lineHit)   nextCode = RES_HIT;
    else if (blockSeen) nextCode = RES_CONFLICT;
    else                nextCode = RES_COLD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resCode  <= RES_IDLE;
    end else begin
      resValid <= fetchReq;
      resCode  <= nextCode;
    end
  end
endmodule

// File: rtl/icls_classifier.sv
module icls_classifier #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              resValid,
  output logic [1:0]        resCode
);
  icls_pkg::strobe_t strobes;
  logic lineHit;
  logic blockSeen;
  logic unusedOffset;

  assign unusedOffset = ^fetchAddr[OFF_W-1:0];

  icls_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .blockAddr(fetchAddr[ADDR_W-1:OFF_W]),
    .lineHit(lineHit), .blockSeen(blockSeen)
  );

  icls_control i_ctl (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq),
    .lineHit(lineHit), .blockSeen(blockSeen),
    .strobes(strobes), .resValid(resValid), .resCode(resCode)
  );
endmodule

// File: rtl/icls_checker.sv
module icls_checker #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              resValid,
  input logic [1:0]        resCode
);
  // R7: result pulse follows each strobe by one cycle
  a_r7_valid_after_req: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> resValid);
  a_r7_quiet_without_req: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq |=> !resValid);
  // R7: idle code when no result
  a_r7_idle_code: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> resCode == 2'b00);
  // R3/R4/R5: a valid result carries one of the three classes
  a_r3_class_legal: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> resCode != 2'b00);
  // R8/R10/R6: back-to-back fetch of the same block must hit
  a_r8_repeat_hits: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && $past(fetchReq) &&
     fetchAddr[ADDR_W-1:OFF_W] == $past(fetchAddr[ADDR_W-1:OFF_W]))
    |=> resCode == 2'b01);
endmodule

bind icls_classifier icls_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_chk (.*);

// File: tb/test_icls_classifier.sv
`timescale 1ns/1ps
module test_icls_classifier;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchReq = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic resValid;
  logic [1:0] resCode;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [1:0] HIT = 2'b01, CM = 2'b10, NM = 2'b11;

  always #2 clk = ~clk;

  icls_classifier i_icls_classifier (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .resValid(resValid), .resCode(resCode)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with result checked.
  task automatic fetch(input logic [15:0] a, input logic [1:0] exp, input string req);
    fetchReq = 1'b1;
    fetchAddr = a;
    @(negedge clk);
    fetchReq = 1'b0;
    check(req, {resValid, resCode}, {1'b1, exp});
  endtask

  task automatic doReset();
    rstN = 1'b0;
    fetchReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 valid low in reset", {resValid, resCode}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tIdle();
    @(negedge clk);
    check("R7 idle", {resValid, resCode}, 3'b000);
  endtask

  task automatic tFetchSequence();
    fetch(16'hCA12, CM, "R2 R4 first touch");
    fetch(16'hCA13, HIT, "R3 R10 same block");
    fetch(16'hCA23, CM, "R1 R4 next index");
    fetch(16'hCA14, HIT, "R3");
    fetch(16'hCA24, HIT, "R3 R8");
    fetch(16'hFE15, CM, "R4 new tag same line");
    fetch(16'hFE13, HIT, "R6 installed");
    fetch(16'hFE23, CM, "R4");
    fetch(16'hFE14, HIT, "R6");
    fetch(16'hFE24, HIT, "R6");
    fetch(16'hCA12, NM, "R5 displaced returns");
    tIdle();
  endtask

  task automatic tPingPong();
    fetch(16'h1230, CM, "R4 ping");
    fetch(16'h4530, CM, "R1 R4 pong same index");
    fetch(16'h1231, NM, "R5 ping again");
    fetch(16'h4532, NM, "R5 pong again");
    fetch(16'h4533, HIT, "R8 back to back hit");
    tIdle();
  endtask

  task automatic tOffsets();
    fetch(16'h7770, CM, "R4");
    for (int i = 1; i < 16; i++) fetch(16'h7770 | 16'(i), HIT, "R10 offset ignored");
    fetch(16'h7780, CM, "R1 bit4 selects line");
    tIdle();
  endtask

  task automatic tResetHistory();
    doReset();
    fetch(16'hCA12, CM, "R9 history cleared");
    fetch(16'h1230, CM, "R9 R2 line invalid");
    fetch(16'hCA12, HIT, "R6");
    tIdle();
  endtask

  initial begin
    doReset();
    tIdle();
    tFetchSequence();
    tPingPong();
    tOffsets();
    tResetHistory();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule